// File: doc/BRIEF.md
# Command Write Buffer with Pending Flags

This block decouples a fast bus-side command decoder from a slow internal execution engine. Each supported command code owns one data register and one pending flag. A write from the decoder lands in the register of its command at once and marks the command pending, whether or not the engine is busy. A newer write to the same command replaces the older data, so only the newest value waits for execution.

The engine runs alongside the buffer. When it is free it takes the pending command with the lowest table index. It latches that command's data, clears the flag, and spends `EXEC_CYCLES` cycles on it. It then emits a one-cycle strobe carrying the code and the data it executed. Because selection goes by table position and not by arrival time, commands can finish in a different order from the one in which they were written. The last value written to each command is still always executed.

A status output goes high only when no command is pending and the engine is idle. A write to a code outside the table changes nothing and produces a one-cycle invalid pulse. The command table is a parameter. By default it holds three codes: 0x00 (page select) at index 0, 0x21 (output setpoint) at index 1 and 0xFD (maker-defined reset) at index 2.

Top module: `cmd_pend_buf`

## Requirements
- R1: After reset, `exec_valid` and `bad_cmd` are 0, `all_clear` is 1, and no strobe appears until a supported write is made.
- R2: A write to a supported code at clock edge E stores `wr_data` as that command's data and sets its pending flag at E, so `all_clear` reads 0 right after E.
- R3: When the engine is idle and one or more commands are pending, the engine fetches the pending command with the lowest table index (0x00 before 0x21 before 0xFD by default) at the next edge and clears that command's flag.
- R4: A command fetched at edge F produces `exec_valid` high for exactly one cycle after edge F+EXEC_CYCLES, with `exec_code` and `exec_data` equal to the fetched code and the data held at fetch. When the block is idle, a write at edge E therefore strobes after edge E+1+EXEC_CYCLES.
- R5: Two or more writes to a command while it waits behind a busy engine cause a single execution, which carries the newest data.
- R6: If a write to a command falls on the same edge at which the engine fetches that command, the flag stays set. The command executes first with the old data and then again with the new data.
- R7: A write to a code not in the table changes no data, no flag and no status. `bad_cmd` goes high for exactly one cycle, right after that write's edge.
- R8: `all_clear` is 1 exactly when no flag is set and the engine is not executing.
- R9: Under any interleaving of writes, once the block is idle, the last strobe seen for each command carries the last data written to that command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request from the bus decoder |
| wr_code | input | CODE_W | Command code of the write |
| wr_data | input | DATA_W | Data word of the write |
| exec_valid | output | 1 | One-cycle strobe at the end of an execution |
| exec_code | output | CODE_W | Code of the command just executed |
| exec_data | output | DATA_W | Data the command was executed with |
| all_clear | output | 1 | 1 when nothing is pending and the engine is idle |
| bad_cmd | output | 1 | One-cycle pulse after a write to an unknown code |

## Verification
Four directed patterns are used, and each one targets a single property:
- A lone write on an idle block fixes the exact latency and shows the status dropping after the write.
- Writes in the order 0xFD, 0x21, 0x00 behind a busy engine separate table-order selection from arrival order.
- Repeated writes behind a busy engine separate overwrite from queuing.
- Back-to-back writes to one code, timed to land on its fetch edge, separate set-wins from clear-wins.

An unknown code is tried on its own to show that it leaves status and strobes untouched. A long seeded random mix of valid and invalid writes then checks that the last executed value of every command matches its last write, and that the number of invalid pulses matches the number of invalid writes.

// File: rtl/cmd_pend_pkg.sv
package cmd_pend_pkg;

   // counter width that never collapses to zero bits
   function automatic int cnt_width(input int span);
      return (span > 1) ? $clog2(span) : 1;
   endfunction

   // default command table: index 0 = 0x00, 1 = 0x21, 2 = 0xFD
   localparam int          DEF_NUM_CMDS = 3;
   localparam int          DEF_CODE_W   = 8;
   localparam logic [23:0] DEF_CODES    = {8'hFD, 8'h21, 8'h00};

endpackage

// File: rtl/cmd_decode.sv
module cmd_decode #(
   parameter int                        NUM_CMDS  = 3,
   parameter int                        CODE_W    = 8,
   parameter logic [NUM_CMDS*CODE_W-1:0] CMD_CODES = {8'hFD, 8'h21, 8'h00}
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_valid,
   input  logic [CODE_W-1:0]   wr_code,
   output logic [NUM_CMDS-1:0] hit_vec,
   output logic                bad_pulse
);

   // elaboration checks: table codes must be distinct
   for (genvar a = 0; a < NUM_CMDS; a++) begin : g_dup_a
      for (genvar b = a + 1; b < NUM_CMDS; b++) begin : g_dup_b
         if (CMD_CODES[a*CODE_W +: CODE_W] == CMD_CODES[b*CODE_W +: CODE_W]) begin : g_dup_err
            $error("cmd_decode: duplicate command code in table");
         end
      end
   end

   for (genvar i = 0; i < NUM_CMDS; i++) begin : g_match
      assign hit_vec[i] = wr_valid && (wr_code == CMD_CODES[i*CODE_W +: CODE_W]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) bad_pulse <= 1'b0;
      else        bad_pulse <= wr_valid && (hit_vec == '0);
   end

   AST_BAD_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && hit_vec == '0) |=> bad_pulse); // R7
   AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec)); // R2

endmodule

// File: rtl/cmd_slot.sv
module cmd_slot #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_i,
   input  logic [DATA_W-1:0] set_data,
   input  logic              clr_i,
   output logic [DATA_W-1:0] data_o,
   output logic              pend_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_o <= 1'b0;
         data_o <= '0;
      end else begin
         if (set_i) begin
            pend_o <= 1'b1;          // a set on the clear edge wins
            data_o <= set_data;
         end else if (clr_i) begin
            pend_o <= 1'b0;
         end
      end
   end

   AST_SET_STORES: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> (pend_o && data_o == $past(set_data))); // R2
   AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && clr_i) |=> pend_o); // R6
   AST_CLR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !pend_o); // R3
   AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !set_i |=> $stable(data_o)); // R5

endmodule

// File: rtl/cmd_pick.sv
module cmd_pick #(
   parameter int NUM_CMDS = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_CMDS-1:0] req,
   output logic [NUM_CMDS-1:0] grant,
   output logic                any_req
);

   if (NUM_CMDS < 1) begin : g_num_err
      $error("cmd_pick: NUM_CMDS must be at least 1");
   end

   assign any_req = |req;

   if (NUM_CMDS == 1) begin : g_single
      assign grant = req;
   end else begin : g_multi
      // lowest-index request wins
      logic [NUM_CMDS-1:0] below;
      assign below[0] = 1'b0;
      for (genvar i = 1; i < NUM_CMDS; i++) begin : g_chain
         assign below[i] = below[i-1] | req[i-1];
      end
      assign grant = req & ~below;
   end

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R3
   AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      any_req |-> ((grant & req) != '0 && ((grant - 1'b1) & req) == '0)); // R3

endmodule

// File: rtl/cmd_exec.sv
module cmd_exec #(
   parameter int DATA_W      = 16,
   parameter int CODE_W      = 8,
   parameter int EXEC_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CODE_W-1:0] start_code,
   input  logic [DATA_W-1:0] start_data,
   output logic              busy_o,
   output logic              done_valid,
   output logic [CODE_W-1:0] done_code,
   output logic [DATA_W-1:0] done_data
);
   import cmd_pend_pkg::*;

   localparam int CNT_W = cnt_width(EXEC_CYCLES);

   if (EXEC_CYCLES < 1) begin : g_len_err
      $error("cmd_exec: EXEC_CYCLES must be at least 1");
   end

   logic              last_cyc;
   logic              launch;
   logic [CODE_W-1:0] cur_code;
   logic [DATA_W-1:0] cur_data;

   assign launch = start_i && !busy_o;

   if (EXEC_CYCLES == 1) begin : g_one
      assign last_cyc = 1'b1;
   end else begin : g_count
      logic [CNT_W-1:0] remain;
      always_ff @(posedge clk) begin
         if (!rst_n)                    remain <= '0;
         else if (launch)               remain <= CNT_W'(EXEC_CYCLES - 1);
         else if (busy_o && remain != 0) remain <= remain - 1'b1;
      end
      assign last_cyc = (remain == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_o     <= 1'b0;
         done_valid <= 1'b0;
         done_code  <= '0;
         done_data  <= '0;
         cur_code   <= '0;
         cur_data   <= '0;
      end else begin
         done_valid <= 1'b0;
         if (launch) begin
            busy_o   <= 1'b1;
            cur_code <= start_code;
            cur_data <= start_data;
         end else if (busy_o && last_cyc) begin
            busy_o     <= 1'b0;
            done_valid <= 1'b1;
            done_code  <= cur_code;
            done_data  <= cur_data;
         end
      end
   end

   // checker: counts busy cycles so the window is not unrolled
   logic [31:0] chk_len;
   always_ff @(posedge clk) begin
      if (!rst_n)                   chk_len <= '0;
      else if (launch)              chk_len <= 32'd1;
      else if (busy_o && !last_cyc) chk_len <= chk_len + 32'd1;
   end

   AST_EXEC_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> (chk_len == 32'(EXEC_CYCLES))); // R4
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid); // R4
   AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> busy_o); // R3

endmodule

// File: rtl/cmd_pend_buf.sv
module cmd_pend_buf #(
   parameter int                        DATA_W      = 16,
   parameter int                        NUM_CMDS    = cmd_pend_pkg::DEF_NUM_CMDS,
   parameter int                        CODE_W      = cmd_pend_pkg::DEF_CODE_W,
   parameter logic [NUM_CMDS*CODE_W-1:0] CMD_CODES  = cmd_pend_pkg::DEF_CODES,
   parameter int                        EXEC_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [CODE_W-1:0] wr_code,
   input  logic [DATA_W-1:0] wr_data,
   output logic              exec_valid,
   output logic [CODE_W-1:0] exec_code,
   output logic [DATA_W-1:0] exec_data,
   output logic              all_clear,
   output logic              bad_cmd
);

   if (DATA_W < 1 || CODE_W < 1) begin : g_width_err
      $error("cmd_pend_buf: widths must be positive");
   end

   logic [NUM_CMDS-1:0] hit_vec;
   logic [NUM_CMDS-1:0] pend_vec;
   logic [NUM_CMDS-1:0] grant;
   logic [NUM_CMDS-1:0] clr_vec;
   logic [DATA_W-1:0]   slot_data [NUM_CMDS];
   logic                any_req;
   logic                busy;
   logic                fetch;
   logic [CODE_W-1:0]   sel_code;
   logic [DATA_W-1:0]   sel_data;

   cmd_decode #(
      .NUM_CMDS (NUM_CMDS),
      .CODE_W   (CODE_W),
      .CMD_CODES(CMD_CODES)
   ) u_decode (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (wr_valid),
      .wr_code  (wr_code),
      .hit_vec  (hit_vec),
      .bad_pulse(bad_cmd)
   );

   for (genvar i = 0; i < NUM_CMDS; i++) begin : g_slot
      cmd_slot #(.DATA_W(DATA_W)) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_i   (hit_vec[i]),
         .set_data(wr_data),
         .clr_i   (clr_vec[i]),
         .data_o  (slot_data[i]),
         .pend_o  (pend_vec[i])
      );
   end

   cmd_pick #(.NUM_CMDS(NUM_CMDS)) u_pick (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (pend_vec),
      .grant  (grant),
      .any_req(any_req)
   );

   assign fetch   = any_req && !busy;
   assign clr_vec = grant & {NUM_CMDS{fetch}};

   always_comb begin
      sel_code = '0;
      sel_data = '0;
      for (int i = 0; i < NUM_CMDS; i++) begin
         if (grant[i]) begin
            sel_code = sel_code | CMD_CODES[i*CODE_W +: CODE_W];
            sel_data = sel_data | slot_data[i];
         end
      end
   end

   cmd_exec #(
      .DATA_W     (DATA_W),
      .CODE_W     (CODE_W),
      .EXEC_CYCLES(EXEC_CYCLES)
   ) u_exec (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (fetch),
      .start_code(sel_code),
      .start_data(sel_data),
      .busy_o    (busy),
      .done_valid(exec_valid),
      .done_code (exec_code),
      .done_data (exec_data)
   );

   assign all_clear = (pend_vec == '0) && !busy;

   AST_WRITE_BLOCKS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vec != '0) |=> !all_clear); // R8
   AST_MISS_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && hit_vec == '0 && pend_vec == '0 && !busy) |=> all_clear); // R7
   AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      exec_valid |-> $past(busy)); // R4

endmodule

// File: tb/tb_cmd_pend_buf.sv
module tb_cmd_pend_buf;

   localparam int DW = 16;
   localparam int CW = 8;
   localparam int N  = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0;
   logic [CW-1:0] wr_code = '0;
   logic [DW-1:0] wr_data = '0;
   logic          exec_valid;
   logic [CW-1:0] exec_code;
   logic [DW-1:0] exec_data;
   logic          all_clear;
   logic          bad_cmd;

   cmd_pend_buf #(.DATA_W(DW), .EXEC_CYCLES(N)) dut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_code(wr_code),
      .wr_data(wr_data), .exec_valid(exec_valid), .exec_code(exec_code),
      .exec_data(exec_data), .all_clear(all_clear), .bad_cmd(bad_cmd)
   );

   always #2.5 clk = ~clk;   // 200 MHz

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int bad_seen = 0;
   bit finished = 0;
   logic [CW-1:0] ev_code [$];
   logic [DW-1:0] ev_data [$];
   int            ev_cyc  [$];

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n && exec_valid) begin
         ev_code.push_back(exec_code);
         ev_data.push_back(exec_data);
         ev_cyc.push_back(cyc);
      end
      if (rst_n && bad_cmd) bad_seen++;
   end

   function automatic int code_idx(input logic [CW-1:0] c);
      case (c)
         8'h00:   return 0;
         8'h21:   return 1;
         8'hFD:   return 2;
         default: return -1;
      endcase
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [CW-1:0] c, input logic [DW-1:0] d, output int at);
      at = cyc;
      wr_valid = 1'b1;
      wr_code  = c;
      wr_data  = d;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 500 && !all_clear; k++) @(negedge clk);
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic clear_ev();
      ev_code.delete();
      ev_data.delete();
      ev_cyc.delete();
   endtask

   task automatic check_ev(input string req, input int idx,
                           input logic [CW-1:0] c, input logic [DW-1:0] d);
      if (idx >= ev_code.size()) begin
         check(req, ev_code.size(), idx + 1);
      end else begin
         check(req, ev_code[idx], c);
         check(req, ev_data[idx], d);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=expired expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      int at;
      int dummy;
      logic [DW-1:0] last_wr [3];
      bit            wrote   [3];
      int            bad_exp;
      void'($urandom(32'd4242));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 exec_valid", exec_valid, 0);
      check("R1 bad_cmd", bad_cmd, 0);
      check("R1 all_clear", all_clear, 1);
      repeat (4) @(negedge clk);
      check("R1 no strobe", ev_code.size(), 0);

      // R2/R4/R8: single write latency on idle block
      clear_ev();
      wr(8'h21, 16'h1234, at);
      check("R2 all_clear drops", all_clear, 0);
      wait_idle();
      check("R8 all_clear back", all_clear, 1);
      check("R4 one strobe", ev_code.size(), 1);
      check_ev("R4 code/data", 0, 8'h21, 16'h1234);
      if (ev_cyc.size() > 0) check("R4 latency", ev_cyc[0], at + 2 + N);

      // R3: table order beats arrival order
      clear_ev();
      wr(8'hFD, 16'hAAAA, dummy);
      wr(8'h21, 16'hBBBB, dummy);
      wr(8'h00, 16'hCCCC, dummy);
      wait_idle();
      check("R3 count", ev_code.size(), 3);
      check_ev("R3 first", 0, 8'hFD, 16'hAAAA);
      check_ev("R3 lowest index next", 1, 8'h00, 16'hCCCC);
      check_ev("R3 last", 2, 8'h21, 16'hBBBB);

      // R5: overwrite while waiting
      clear_ev();
      wr(8'hFD, 16'h0F0F, dummy);
      wr(8'h21, 16'h1111, dummy);
      wr(8'h21, 16'h2222, dummy);
      wr(8'h21, 16'h3333, dummy);
      wait_idle();
      check("R5 count", ev_code.size(), 2);
      check_ev("R5 newest only", 1, 8'h21, 16'h3333);

      // R6: write on the fetch edge of the same command
      clear_ev();
      wr(8'h21, 16'h5A5A, dummy);
      wr(8'h21, 16'hA5A5, dummy);
      wait_idle();
      check("R6 count", ev_code.size(), 2);
      check_ev("R6 old data", 0, 8'h21, 16'h5A5A);
      check_ev("R6 new data", 1, 8'h21, 16'hA5A5);

      // R7: unsupported code
      clear_ev();
      bad_seen = 0;
      wr(8'h55, 16'hDEAD, dummy);
      check("R7 pulse", bad_cmd, 1);
      check("R7 all_clear kept", all_clear, 1);
      @(negedge clk);
      check("R7 pulse ends", bad_cmd, 0);
      wait_idle();
      check("R7 no strobe", ev_code.size(), 0);
      check("R7 pulse count", bad_seen, 1);

      // R9: random mix
      clear_ev();
      bad_seen = 0;
      bad_exp = 0;
      for (int i = 0; i < 3; i++) wrote[i] = 0;
      for (int t = 0; t < 3000; t++) begin
         if ($urandom % 2 == 0) begin
            int r;
            logic [CW-1:0] c;
            logic [DW-1:0] d;
            r = $urandom % 8;
            d = DW'($urandom);
            case (r)
               0, 1:    c = 8'h00;
               2, 3:    c = 8'h21;
               4, 5:    c = 8'hFD;
               default: c = CW'(8'h40 + r);
            endcase
            if (code_idx(c) >= 0) begin
               last_wr[code_idx(c)] = d;
               wrote[code_idx(c)]   = 1;
            end else begin
               bad_exp++;
            end
            wr(c, d, dummy);
         end else begin
            @(negedge clk);
         end
      end
      wait_idle();
      check("R7 random pulses", bad_seen, bad_exp);
      for (int i = 0; i < 3; i++) begin
         if (wrote[i]) begin
            int last = -1;
            for (int e = 0; e < ev_code.size(); e++)
               if (code_idx(ev_code[e]) == i) last = e;
            if (last < 0) check("R9 executed", 0, 1);
            else          check("R9 final value", ev_data[last], last_wr[i]);
         end
      end
      begin
         int unk = 0;
         for (int e = 0; e < ev_code.size(); e++)
            if (code_idx(ev_code[e]) < 0) unk++;
         check("R7 no unknown strobe", unk, 0);
      end
      check("R8 idle at end", all_clear, 1);

      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule